// File: doc/BRIEF.md
# Counter Register Access Port

This block is the register-access front end of a bank of event counters. Software reaches the general counters through two write views. The legacy view is 32 bits wide: it keeps the low word of the data and copies bit 31 up to the counter width. The full-width view stores the data as it is, but only when the full-width capability is advertised and no data bit lies above the implemented width. The fixed counters have their own direct read and write operations. A fixed write keeps only the bits that fit.

An index read reaches either counter group through one 32-bit selector. Bit 30 picks the fixed group. Bits 29:0 give the counter number. Bit 31 asks for a fast read, which returns only the low 32 bits. A request that is malformed or not allowed returns an error and changes nothing.

Each request is accepted in one cycle. Its response, with a valid flag, an error flag and read data, appears on the next cycle. The counter storage sits behind the decoder, and the decoder drives its write strobes. The counting arithmetic lives elsewhere.

Top module: `ctr_acc_port`

## Requirements
- R1: After synchronous reset, rsp_valid is 0 and every general and fixed counter reads as zero.
- R2: A request sampled with req_valid high produces rsp_valid high on the next cycle. A cycle without a request produces rsp_valid low on the next cycle.
- R3: Op 0 (legacy general write) stores data bits 31:0 sign-extended from bit 31, masked to GEN_W. Data bits 63:32 are ignored and raise no error.
- R4: Op 1 (full-width general write) stores the data unchanged when caps bit 13 is set and all data bits at GEN_W and above are zero.
- R5: Op 1 with any data bit at GEN_W or above set returns rsp_err=1, and the counter keeps its old value.
- R6: When caps bit 13 is clear, op 1 and op 3 (full-width general read) return rsp_err=1 and change no counter.
- R7: Op 2 (legacy general read) and op 3 return the same stored value of the selected general counter, zero-extended to 64 bits.
- R8: Op 4 (fixed write) stores the data masked to FIX_W with no error. Op 5 (fixed read) returns the stored value.
- R9: Op 6 (index read) takes the counter number from req_sel bits 29:0. It reads a fixed counter when req_sel bit 30 is 1 and a general counter when it is 0.
- R10: For op 6 with req_sel bit 31 set, rsp_rdata is the low 32 bits of the counter with bits 63:32 zero.
- R11: A counter number at or above the implemented count of the addressed group, in any op, returns rsp_err=1 and rsp_rdata=0 and changes no counter. Op 7 always returns an error.
- R12: A write that succeeds responds with rsp_err=0 and rsp_rdata=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present this cycle |
| req_op | input | 3 | Operation code (0..7, see requirements) |
| req_sel | input | 32 | Counter number in bits 29:0; bit 30 selects the fixed group and bit 31 selects a fast read (index read only) |
| req_wdata | input | 64 | Write data |
| caps | input | CAP_W | Capability vector; bit 13 enables the full-width view |
| rsp_valid | output | 1 | Response valid, one cycle after the request |
| rsp_err | output | 1 | Request faulted |
| rsp_rdata | output | 64 | Read data, zero on writes and faults |

## Verification
The hardest case to reach is a rejected full-width write whose data sits just above the counter width, followed by a proof that the counter kept its earlier contents. Reaching it needs the capability bit set, a valid counter number, and a single stray bit at position GEN_W.

The stimulus writes a known pattern first. It then sends the rejected write, both with a lone bit 48 and with a fully set upper word, and reads the counter back through both views. Random traffic then mixes out-of-range numbers, an unset capability bit and wide data, so that rejected and accepted writes interleave against a reference model.

// File: rtl/ctr_acc_pkg.sv
package ctr_acc_pkg;

    localparam int ACC_DW       = 64;
    localparam int SEL_FIX_BIT  = 30;
    localparam int SEL_FAST_BIT = 31;
    localparam int SEL_NUM_W    = 30;
    localparam int CAP_FULL_BIT = 13;

    typedef enum logic [2:0] {
        OP_GWR_LEG  = 3'd0,
        OP_GWR_FULL = 3'd1,
        OP_GRD_LEG  = 3'd2,
        OP_GRD_FULL = 3'd3,
        OP_FWR      = 3'd4,
        OP_FRD      = 3'd5,
        OP_IDX_RD   = 3'd6,
        OP_RSVD     = 3'd7
    } acc_op_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_GEN  = 2'd1,
        SRC_FIX  = 2'd2
    } rd_src_e;

    typedef struct packed {
        logic                 err;
        logic                 gen_we;
        logic                 fix_we;
        logic [ACC_DW-1:0]    gen_wd;
        logic [ACC_DW-1:0]    fix_wd;
        rd_src_e              src;
        logic                 fast;
        logic [SEL_NUM_W-1:0] num;
    } acc_dec_t;

    function automatic logic [ACC_DW-1:0] width_mask(input int w);
        logic [ACC_DW-1:0] m;
        m = '0;
        for (int i = 0; i < ACC_DW; i++) begin
            if (i < w) m[i] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [ACC_DW-1:0] legacy_extend(input logic [ACC_DW-1:0] d);
        return {{(ACC_DW-32){d[31]}}, d[31:0]};
    endfunction

endpackage

// File: rtl/ctr_acc_decode.sv
module ctr_acc_decode
    import ctr_acc_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int NUM_FIX = 3,
    parameter int GEN_W   = 48,
    parameter int FIX_W   = 40,
    parameter int CAP_W   = 16
) (
    input  logic              valid,
    input  logic [2:0]        op,
    input  logic [31:0]       sel,
    input  logic [ACC_DW-1:0] wdata,
    input  logic [CAP_W-1:0]  caps,
    output acc_dec_t          dec
);
    localparam logic [ACC_DW-1:0]    GEN_MASK = width_mask(GEN_W);
    localparam logic [ACC_DW-1:0]    FIX_MASK = width_mask(FIX_W);
    localparam logic [SEL_NUM_W-1:0] GEN_LIM  = SEL_NUM_W'(NUM_GEN);
    localparam logic [SEL_NUM_W-1:0] FIX_LIM  = SEL_NUM_W'(NUM_FIX);

    acc_op_e              op_e;
    logic [SEL_NUM_W-1:0] num;
    logic                 gen_ok;
    logic                 fix_ok;
    logic                 cap_ok;
    logic                 wide;

    assign op_e   = acc_op_e'(op);
    assign num    = sel[SEL_NUM_W-1:0];
    assign gen_ok = num < GEN_LIM;
    assign fix_ok = num < FIX_LIM;
    assign cap_ok = caps[CAP_FULL_BIT];
    assign wide   = |(wdata & ~GEN_MASK);

    always_comb begin
        dec        = '0;
        dec.num    = num;
        dec.src    = SRC_NONE;
        dec.gen_wd = legacy_extend(wdata) & GEN_MASK;
        dec.fix_wd = wdata & FIX_MASK;
        if (valid) begin
            case (op_e)
                OP_GWR_LEG: begin
                    if (gen_ok) dec.gen_we = 1'b1;
                    else        dec.err    = 1'b1;
                end
                OP_GWR_FULL: begin
                    if (gen_ok && cap_ok && !wide) begin
                        dec.gen_we = 1'b1;
                        dec.gen_wd = wdata;
                    end else begin
                        dec.err = 1'b1;
                    end
                end
                OP_GRD_LEG: begin
                    if (gen_ok) dec.src = SRC_GEN;
                    else        dec.err = 1'b1;
                end
                OP_GRD_FULL: begin
                    if (gen_ok && cap_ok) dec.src = SRC_GEN;
                    else                  dec.err = 1'b1;
                end
                OP_FWR: begin
                    if (fix_ok) dec.fix_we = 1'b1;
                    else        dec.err    = 1'b1;
                end
                OP_FRD: begin
                    if (fix_ok) dec.src = SRC_FIX;
                    else        dec.err = 1'b1;
                end
                OP_IDX_RD: begin
                    dec.fast = sel[SEL_FAST_BIT];
                    if (sel[SEL_FIX_BIT]) begin
                        if (fix_ok) dec.src = SRC_FIX;
                        else        dec.err = 1'b1;
                    end else begin
                        if (gen_ok) dec.src = SRC_GEN;
                        else        dec.err = 1'b1;
                    end
                end
                default: dec.err = 1'b1;
            endcase
        end
    end
endmodule

// File: rtl/ctr_acc_bank.sv
module ctr_acc_bank
    import ctr_acc_pkg::*;
#(
    parameter int NUM = 4,
    parameter int W   = 48
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 we,
    input  logic [SEL_NUM_W-1:0] wsel,
    input  logic [ACC_DW-1:0]    wdata,
    input  logic [SEL_NUM_W-1:0] rsel,
    output logic [ACC_DW-1:0]    rdata
);
    logic [NUM-1:0][W-1:0] vals;

    for (genvar i = 0; i < NUM; i++) begin : g_entry
        logic [W-1:0] q;
        always_ff @(posedge clk) begin
            if (rst) begin
                q <= '0;
            end else if (we && (wsel == SEL_NUM_W'(i))) begin
                q <= wdata[W-1:0];
            end
        end
        assign vals[i] = q;
    end

    always_comb begin
        rdata = '0;
        for (int i = 0; i < NUM; i++) begin
            if (rsel == SEL_NUM_W'(i)) rdata = ACC_DW'(vals[i]);
        end
    end
endmodule

// File: rtl/ctr_acc_port.sv
module ctr_acc_port
    import ctr_acc_pkg::*;
#(
    parameter int NUM_GEN = 4,
    parameter int NUM_FIX = 3,
    parameter int GEN_W   = 48,
    parameter int FIX_W   = 40,
    parameter int CAP_W   = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic [2:0]        req_op,
    input  logic [31:0]       req_sel,
    input  logic [63:0]       req_wdata,
    input  logic [CAP_W-1:0]  caps,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [63:0]       rsp_rdata
);
    acc_dec_t          dec;
    logic [ACC_DW-1:0] gen_rd;
    logic [ACC_DW-1:0] fix_rd;
    logic [ACC_DW-1:0] rd_next;
    logic              gen_we;
    logic              fix_we;

    ctr_acc_decode #(
        .NUM_GEN(NUM_GEN), .NUM_FIX(NUM_FIX),
        .GEN_W(GEN_W), .FIX_W(FIX_W), .CAP_W(CAP_W)
    ) u_decode (
        .valid (req_valid),
        .op    (req_op),
        .sel   (req_sel),
        .wdata (req_wdata),
        .caps  (caps),
        .dec   (dec)
    );

    assign gen_we = dec.gen_we;
    assign fix_we = dec.fix_we;

    ctr_acc_bank #(.NUM(NUM_GEN), .W(GEN_W)) u_gen_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (gen_we),
        .wsel  (dec.num),
        .wdata (dec.gen_wd),
        .rsel  (dec.num),
        .rdata (gen_rd)
    );

    ctr_acc_bank #(.NUM(NUM_FIX), .W(FIX_W)) u_fix_bank (
        .clk   (clk),
        .rst   (rst),
        .we    (fix_we),
        .wsel  (dec.num),
        .wdata (dec.fix_wd),
        .rsel  (dec.num),
        .rdata (fix_rd)
    );

    always_comb begin
        case (dec.src)
            SRC_GEN: rd_next = gen_rd;
            SRC_FIX: rd_next = fix_rd;
            default: rd_next = '0;
        endcase
        if (dec.fast) rd_next = {32'b0, rd_next[31:0]};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_valid <= 1'b0;
            rsp_err   <= 1'b0;
            rsp_rdata <= '0;
        end else begin
            rsp_valid <= req_valid;
            rsp_err   <= dec.err;
            rsp_rdata <= rd_next;
        end
    end
endmodule

// File: rtl/ctr_acc_checker.sv
module ctr_acc_checker
    import ctr_acc_pkg::*;
#(
    parameter int GEN_W = 48,
    parameter int CAP_W = 16
) (
    input logic             clk,
    input logic             rst,
    input logic             req_valid,
    input logic [2:0]       req_op,
    input logic [31:0]      req_sel,
    input logic [63:0]      req_wdata,
    input logic [CAP_W-1:0] caps,
    input logic             gen_we,
    input logic             fix_we,
    input logic             rsp_valid,
    input logic             rsp_err,
    input logic [63:0]      rsp_rdata
);
    localparam logic [63:0] HI_MASK = ~width_mask(GEN_W);

    AST_RSP_AFTER_REQ: assert property (@(posedge clk) disable iff (rst)
        req_valid |=> rsp_valid); // R2
    AST_NO_RSP_IDLE: assert property (@(posedge clk) disable iff (rst)
        !req_valid |=> !rsp_valid); // R2
    AST_ERR_ZERO_DATA: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid && rsp_err) |-> (rsp_rdata == 64'd0)); // R11
    AST_FAST_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd6 && req_sel[SEL_FAST_BIT]) |=> (rsp_rdata[63:32] == 32'd0)); // R10
    AST_NO_CAP_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && (req_op == 3'd1 || req_op == 3'd3) && !caps[CAP_FULL_BIT]) |=> rsp_err); // R6
    AST_WIDE_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd1 && |(req_wdata & HI_MASK)) |=> rsp_err); // R5
    AST_WIDE_NO_STROBE: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd1 && |(req_wdata & HI_MASK)) |-> !gen_we); // R5
    AST_STROBE_NO_ERR: assert property (@(posedge clk) disable iff (rst)
        (gen_we || fix_we) |=> (!rsp_err && rsp_rdata == 64'd0)); // R12
    AST_RSVD_FAULT: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_op == 3'd7) |=> rsp_err); // R11
endmodule

bind ctr_acc_port ctr_acc_checker #(.GEN_W(GEN_W), .CAP_W(CAP_W)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_op    (req_op),
    .req_sel   (req_sel),
    .req_wdata (req_wdata),
    .caps      (caps),
    .gen_we    (gen_we),
    .fix_we    (fix_we),
    .rsp_valid (rsp_valid),
    .rsp_err   (rsp_err),
    .rsp_rdata (rsp_rdata)
);

// File: tb/ctr_acc_port_bench.sv
`timescale 1ns/1ps
module ctr_acc_port_bench;
    localparam int NG = 4;
    localparam int NF = 3;
    localparam int GW = 48;
    localparam int FW = 40;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          req_valid = 1'b0;
    logic [2:0]    req_op = '0;
    logic [31:0]   req_sel = '0;
    logic [63:0]   req_wdata = '0;
    logic [CW-1:0] caps = '0;
    logic          rsp_valid;
    logic          rsp_err;
    logic [63:0]   rsp_rdata;

    int checks = 0;
    int failures = 0;
    bit done = 0;

    logic [63:0] gm [NG];
    logic [63:0] fm [NF];

    always #4 clk = ~clk;

    ctr_acc_port #(.NUM_GEN(NG), .NUM_FIX(NF), .GEN_W(GW), .FIX_W(FW), .CAP_W(CW)) u_ctr_acc_port (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
        .req_sel(req_sel), .req_wdata(req_wdata), .caps(caps),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata));

    function automatic logic [63:0] msk(input int w);
        return (w >= 64) ? '1 : ((64'd1 << w) - 64'd1);
    endfunction

    task automatic check(input bit ok, input string tag, input logic [64:0] act, input logic [64:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Model the response and state update, drive one request, check the response.
    task automatic req(input logic [2:0] op, input logic [31:0] sel, input logic [63:0] wd,
                       input string tag, output logic [63:0] got);
        logic        e_err;
        logic [63:0] e_dat;
        logic [29:0] n;
        bit          capok;
        bit          is_fix;
        e_err = 1'b0;
        e_dat = '0;
        n = sel[29:0];
        capok = caps[13];
        case (op)
            3'd0: if (n < NG) gm[n] = {{32{wd[31]}}, wd[31:0]} & msk(GW); else e_err = 1;
            3'd1: if (n < NG && capok && (wd & ~msk(GW)) == 0) gm[n] = wd; else e_err = 1;
            3'd2: if (n < NG) e_dat = gm[n]; else e_err = 1;
            3'd3: if (n < NG && capok) e_dat = gm[n]; else e_err = 1;
            3'd4: if (n < NF) fm[n] = wd & msk(FW); else e_err = 1;
            3'd5: if (n < NF) e_dat = fm[n]; else e_err = 1;
            3'd6: begin
                is_fix = sel[30];
                if (is_fix && n < NF) e_dat = fm[n];
                else if (!is_fix && n < NG) e_dat = gm[n];
                else e_err = 1;
                if (sel[31]) e_dat = {32'd0, e_dat[31:0]};
            end
            default: e_err = 1;
        endcase
        @(negedge clk);
        req_valid = 1'b1;
        req_op = op;
        req_sel = sel;
        req_wdata = wd;
        @(posedge clk);
        #1;
        req_valid = 1'b0;
        got = rsp_rdata;
        check(rsp_valid === 1'b1, "R2", {64'd0, rsp_valid}, 65'd1);
        check({rsp_err, rsp_rdata} === {e_err, e_dat}, tag, {rsp_err, rsp_rdata}, {e_err, e_dat});
    endtask

    function automatic string op_tag(input logic [2:0] op, input logic [31:0] sel);
        if (op == 3'd0) return "R3";
        if (op == 3'd1) return (caps[13] ? "R5" : "R6");
        if (op == 3'd2 || op == 3'd3) return "R7";
        if (op == 3'd4 || op == 3'd5) return "R8";
        if (op == 3'd6) return (sel[31] ? "R10" : "R9");
        return "R11";
    endfunction

    initial begin
        #(8 * 190000);
        if (!done) begin
            failures++;
            checks++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [63:0] g;
        void'($urandom(32'h5EED_1234));
        for (int i = 0; i < NG; i++) gm[i] = '0;
        for (int i = 0; i < NF; i++) fm[i] = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(rsp_valid === 1'b0, "R1", {64'd0, rsp_valid}, 65'd0);
        for (int i = 0; i < NG; i++) req(3'd2, i, 64'd0, "R1", g);
        for (int i = 0; i < NF; i++) req(3'd5, i, 64'd0, "R1", g);

        caps = 16'h2000;
        req(3'd0, 1, 64'hFFFF_FF01_8000_0000, "R12", g);
        req(3'd3, 1, 64'd0, "R7", g);
        check(g === 64'h0000_FFFF_8000_0000, "R3", {1'b0, g}, {1'b0, 64'h0000_FFFF_8000_0000});
        req(3'd2, 1, 64'd0, "R7", g);
        req(3'd0, 2, 64'h0000_0123_7FFF_FFFF, "R3", g);
        req(3'd2, 2, 64'd0, "R3", g);
        check(g === 64'h7FFF_FFFF, "R3", {1'b0, g}, {1'b0, 64'h7FFF_FFFF});

        req(3'd1, 0, 64'h0000_FF01_2345_6789, "R4", g);
        req(3'd3, 0, 64'd0, "R4", g);
        req(3'd1, 0, 64'hFFFF_FF01_2345_6789, "R5", g);
        req(3'd1, 0, 64'h0001_0000_0000_0000, "R5", g);
        req(3'd2, 0, 64'd0, "R5", g);
        check(g === 64'h0000_FF01_2345_6789, "R5", {1'b0, g}, {1'b0, 64'h0000_FF01_2345_6789});

        caps = 16'hDFFF;
        req(3'd1, 3, 64'h5, "R6", g);
        req(3'd3, 3, 64'd0, "R6", g);
        req(3'd2, 3, 64'd0, "R6", g);
        caps = 16'h2000;

        req(3'd4, 1, 64'hFFFF_FFFF_FFFF_FFFF, "R8", g);
        req(3'd5, 1, 64'd0, "R8", g);
        check(g === 64'h00FF_FFFF_FFFF, "R8", {1'b0, g}, {1'b0, 64'h00FF_FFFF_FFFF});

        req(3'd6, 32'h0000_0001, 64'd0, "R9", g);
        req(3'd6, 32'h4000_0001, 64'd0, "R9", g);
        req(3'd6, 32'h8000_0000, 64'd0, "R10", g);
        check(g === 64'h2345_6789, "R10", {1'b0, g}, {1'b0, 64'h2345_6789});
        req(3'd6, 32'hC000_0001, 64'd0, "R10", g);

        req(3'd6, 32'h0000_0004, 64'd0, "R11", g);
        req(3'd6, 32'h4000_0003, 64'd0, "R11", g);
        req(3'd6, 32'h3FFF_FFFF, 64'd0, "R11", g);
        req(3'd0, 4, 64'h1234, "R11", g);
        req(3'd4, 3, 64'h1234, "R11", g);
        req(3'd7, 0, 64'h1, "R11", g);
        for (int i = 0; i < NG; i++) req(3'd2, i, 64'd0, "R11", g);

        @(negedge clk);
        @(negedge clk);
        check(rsp_valid === 1'b0, "R2", {64'd0, rsp_valid}, 65'd0);

        for (int k = 0; k < 600; k++) begin
            logic [2:0]  op;
            logic [31:0] sel;
            logic [63:0] wd;
            int          pick;
            op = 3'($urandom % 8);
            sel = {$urandom % 2 == 0 ? 1'b0 : 1'b1, $urandom % 2 == 0 ? 1'b0 : 1'b1,
                   30'($urandom % 6)};
            pick = $urandom % 4;
            wd = {$urandom, $urandom};
            if (pick == 1) wd = wd & msk(GW);
            else if (pick == 2) wd = (wd & msk(GW)) | (64'd1 << (GW + ($urandom % (64 - GW))));
            else if (pick == 3) wd = {32'd0, $urandom};
            caps = CW'($urandom);
            if ($urandom % 4 != 0) caps[13] = 1'b1;
            req(op, sel, wd, op_tag(op, sel), g);
        end

        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule